// File: doc/BRIEF.md
# Min/Max Acquisition Load Selector

This block decides, on every cycle, whether the minimum-sample register and the maximum-sample register of an acquisition path should capture the current sample byte. A processor writes a two-bit mode word. The block combines that word with a small start-of-interval sequencer to form a two-bit select code. The select code picks one of four load sources:

- a dual "seed" load that starts a new interval,
- the results of the min and max comparators,
- the odd-sample strobe for plain sampling,
- the even and odd strobes separately for paired two-channel capture.

The comparators and the storage registers sit outside the block. The block only produces their load enables.

The conversion clock is not used as a clock. It arrives as two signals in the system clock domain. `conv_tick` is a one-cycle pulse on each rising conversion edge. `conv_low` is high during the low half of the conversion period. In every mode except paired capture, the enables reach the outputs only while `conv_low` is high. This gives the comparators half a period to settle, and it limits the seed load to half a conversion period.

Top module: `acq_load_select`

## Requirements
- R1: After reset the mode word is 01 (plain sampling), `sel_code` reads 01, and both load outputs are low while the strobes are low.
- R2: A cycle with `mode_we` high stores `mode_wdata` as the mode word. Encodings: 00 is paired XY capture, 01 is plain sampling, and 10 or 11 is min/max tracking. Bit 1 of `sel_code` always equals bit 1 of the mode word.
- R3: In plain sampling `sel_code` is 01, and both loads equal `odd_stb`, gated by `conv_low`.
- R4: In min/max mode, an `even_stb` arms the sequencer. The first `conv_tick` after arming sets `sel_code` to 11 (seed) from the next cycle on.
- R5: The seed select lasts until the next `conv_tick`. From the cycle after that tick, `sel_code` is 10 (compare).
- R6: In every mode other than 00, both loads are low whenever `conv_low` is low.
- R7: While `sel_code` is 11, both loads are high when `conv_low` is high.
- R8: While `sel_code` is 10, `min_load` follows `new_min` and `max_load` follows `new_max` when `conv_low` is high. An `even_stb` that arrives during arming or seeding is ignored.
- R9: Each later `even_stb` in compare mode starts another seed sequence, so there is one seed per save interval.
- R10: In mode 00, `sel_code` is 00, `min_load` equals `even_stb` and `max_load` equals `odd_stb`, whatever the level of `conv_low`. Strobes and ticks never produce a seed select.
- R11: A write that changes the mode word returns the sequencer to idle on the same clock edge. A write of the unchanged value leaves an armed or seeding sequence running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_tick | input | 1 | One-cycle pulse on each rising conversion edge |
| conv_low | input | 1 | High during the low half of the conversion period |
| even_stb | input | 1 | Even-sample strobe |
| odd_stb | input | 1 | Odd-sample strobe |
| new_min | input | 1 | Comparator result: the sample is below the stored minimum |
| new_max | input | 1 | Comparator result: the sample is above the stored maximum |
| mode_we | input | 1 | Mode word write enable |
| mode_wdata | input | 2 | Mode word write data |
| min_load | output | 1 | Load enable for the minimum register |
| max_load | output | 1 | Load enable for the maximum register |
| sel_code | output | 2 | Current select code (11 seed, 10 compare, 01 sampling, 00 XY) |

## Verification
A wrong sequencer state shows on `sel_code` in the cycle after the conversion tick that should have moved it. The load pair shows it in the next `conv_low` window, as a missing or extra dual load or as comparator results being routed during the seed window. A stale mode word shows at once on bit 1 of `sel_code`. A missed reset on a mode change shows as a seed select that appears in the new mode. The directed scenarios sample `sel_code` one cycle after each tick and each write, so every such fault appears within two clocks of its cause.

// File: rtl/acq_sel_pkg.sv
package acq_sel_pkg;
    localparam int MODE_W = 2;

    localparam logic [MODE_W-1:0] MODE_XY   = 2'b00;
    localparam logic [MODE_W-1:0] MODE_SAMP = 2'b01;

    localparam logic [1:0] SEL_SEED = 2'b11;
    localparam logic [1:0] SEL_CMP  = 2'b10;
    localparam logic [1:0] SEL_SAMP = 2'b01;
    localparam logic [1:0] SEL_XY   = 2'b00;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ARM  = 2'd1,
        SQ_SEED = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
    } mode_regs_t;

    typedef struct packed {
        seq_state_e st;
    } seq_regs_t;
endpackage

// File: rtl/acq_mode_reg.sv
module acq_mode_reg
    import acq_sel_pkg::*;
#(
    parameter logic [MODE_W-1:0] RESET_MODE = MODE_SAMP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic [MODE_W-1:0] mode,
    output logic              mode_chg
);
    mode_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (mode_we) begin
            r_d.mode = mode_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.mode <= RESET_MODE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mode     = r_q.mode;
    assign mode_chg = mode_we && (mode_wdata != r_q.mode);

    // R2: a write lands in the mode word on the next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (mode == $past(mode_wdata)));
endmodule

// File: rtl/acq_seed_seq.sv
module acq_seed_seq
    import acq_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              mode_chg,
    input  logic              even_stb,
    input  logic              conv_tick,
    output logic              low_bit,
    output logic              seeding
);
    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (mode_chg || !mode[1]) begin
            r_d.st = SQ_IDLE;
        end else begin
            case (r_q.st)
                SQ_IDLE: if (even_stb)  r_d.st = SQ_ARM;
                SQ_ARM:  if (conv_tick) r_d.st = SQ_SEED;
                SQ_SEED: if (conv_tick) r_d.st = SQ_IDLE;
                default:                r_d.st = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st <= SQ_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign seeding = (r_q.st == SQ_SEED);
    assign low_bit = (mode == MODE_SAMP) || (mode[1] && seeding);

    // R4: seed is entered only from armed on a conversion tick
    a_r4_seed_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (seeding && !$past(seeding)) |-> ($past(conv_tick) && $past(r_q.st == SQ_ARM)));

    // R5: seed persists until a tick or a mode change
    a_r5_seed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seeding && !conv_tick && !mode_chg) |=> seeding);

    // R11: a changing write always leaves the sequencer idle
    a_r11_chg_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (r_q.st == SQ_IDLE));
endmodule

// File: rtl/acq_load_mux.sv
module acq_load_mux
    import acq_sel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       conv_low,
    input  logic       even_stb,
    input  logic       odd_stb,
    input  logic       new_min,
    input  logic       new_max,
    output logic       min_load,
    output logic       max_load
);
    logic gate;
    logic raw_min, raw_max;

    always_comb begin
        gate = conv_low || (sel == SEL_XY);
        case (sel)
            SEL_SEED: begin raw_min = 1'b1;     raw_max = 1'b1;     end
            SEL_CMP:  begin raw_min = new_min;  raw_max = new_max;  end
            SEL_SAMP: begin raw_min = odd_stb;  raw_max = odd_stb;  end
            default:  begin raw_min = even_stb; raw_max = odd_stb;  end
        endcase
        min_load = raw_min && gate;
        max_load = raw_max && gate;
    end

    // R6: no load escapes during the high half outside XY mode
    a_r6_gate_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_low && sel != SEL_XY) |-> (!min_load && !max_load));

    // R7: seed window loads both registers
    a_r7_seed_dual: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_SEED && conv_low) |-> (min_load && max_load));

    // R10: XY pairs the even strobe with min and the odd strobe with max
    a_r10_xy_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_XY) |-> (min_load == even_stb && max_load == odd_stb));
endmodule

// File: rtl/acq_load_select.sv
module acq_load_select
    import acq_sel_pkg::*;
#(
    parameter logic [MODE_W-1:0] RESET_MODE = MODE_SAMP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_tick,
    input  logic              conv_low,
    input  logic              even_stb,
    input  logic              odd_stb,
    input  logic              new_min,
    input  logic              new_max,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic              min_load,
    output logic              max_load,
    output logic [1:0]        sel_code
);
    logic [MODE_W-1:0] mode;
    logic              mode_chg;
    logic              low_bit;
    logic              seeding;

    acq_mode_reg #(.RESET_MODE(RESET_MODE)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .mode       (mode),
        .mode_chg   (mode_chg)
    );

    acq_seed_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .mode_chg  (mode_chg),
        .even_stb  (even_stb),
        .conv_tick (conv_tick),
        .low_bit   (low_bit),
        .seeding   (seeding)
    );

    assign sel_code = {mode[1], low_bit};

    acq_load_mux u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel_code),
        .conv_low (conv_low),
        .even_stb (even_stb),
        .odd_stb  (odd_stb),
        .new_min  (new_min),
        .new_max  (new_max),
        .min_load (min_load),
        .max_load (max_load)
    );

    // R2: the upper select bit tracks the stored compare-enable bit
    a_r2_upper_bit: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (sel_code[1] == $past(mode_wdata[1])));

    // R10: XY mode never shows a seed state
    a_r10_xy_noseed: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_XY) |-> !seeding);
endmodule

// File: tb/tb_acq_load_select.sv
module tb_acq_load_select;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_tick = 1'b0, conv_low = 1'b0;
    logic       even_stb = 1'b0, odd_stb = 1'b0;
    logic       new_min = 1'b0, new_max = 1'b0;
    logic       mode_we = 1'b0;
    logic [1:0] mode_wdata = 2'b00;
    logic       min_load, max_load;
    logic [1:0] sel_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acq_load_select dut (
        .clk(clk), .rst_n(rst_n), .conv_tick(conv_tick), .conv_low(conv_low),
        .even_stb(even_stb), .odd_stb(odd_stb), .new_min(new_min), .new_max(new_max),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .min_load(min_load), .max_load(max_load), .sel_code(sel_code)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        conv_tick = 1'b0; even_stb = 1'b0; mode_we = 1'b0;
    endtask

    task automatic expect_out(string req, logic [1:0] es, logic emin, logic emax);
        #1;
        checks++;
        if (sel_code !== es || min_load !== emin || max_load !== emax) begin
            fails++;
            $display("FAIL %s: sel=%b min=%b max=%b expected sel=%b min=%b max=%b",
                     req, sel_code, min_load, max_load, es, emin, emax);
        end
    endtask

    task automatic write_mode(logic [1:0] v);
        mode_we = 1'b1; mode_wdata = v;
        step();
    endtask

    task automatic t_reset();
        conv_low = 1'b1;
        expect_out("R1", 2'b01, 1'b0, 1'b0);
    endtask

    task automatic t_sampling();
        odd_stb = 1'b1; conv_low = 1'b1;
        expect_out("R3", 2'b01, 1'b1, 1'b1);
        conv_low = 1'b0;
        expect_out("R6", 2'b01, 1'b0, 1'b0);
        odd_stb = 1'b0; conv_low = 1'b1;
        expect_out("R3", 2'b01, 1'b0, 1'b0);
    endtask

    task automatic t_minmax();
        write_mode(2'b10);
        conv_low = 1'b1; new_min = 1'b0; new_max = 1'b0;
        expect_out("R2", 2'b10, 1'b0, 1'b0);
        conv_tick = 1'b1; step();             // tick without arming: no seed
        expect_out("R4", 2'b10, 1'b0, 1'b0);
        even_stb = 1'b1; step();              // arm
        expect_out("R4", 2'b10, 1'b0, 1'b0);
        even_stb = 1'b1; step();              // ignored while armed
        conv_tick = 1'b1; step();             // enter seed
        expect_out("R4", 2'b11, 1'b1, 1'b1);
        expect_out("R7", 2'b11, 1'b1, 1'b1);
        conv_low = 1'b0;
        expect_out("R6", 2'b11, 1'b0, 1'b0);
        conv_low = 1'b1; new_min = 1'b1;
        expect_out("R7", 2'b11, 1'b1, 1'b1);
        even_stb = 1'b1; step();              // ignored in seed
        expect_out("R8", 2'b11, 1'b1, 1'b1);
        conv_tick = 1'b1; step();             // leave seed
        expect_out("R5", 2'b10, 1'b1, 1'b0);
        new_min = 1'b0; new_max = 1'b1;
        expect_out("R8", 2'b10, 1'b0, 1'b1);
        conv_low = 1'b0;
        expect_out("R6", 2'b10, 1'b0, 1'b0);
        conv_low = 1'b1; new_max = 1'b0;
        even_stb = 1'b1; step();
        conv_tick = 1'b1; step();
        expect_out("R9", 2'b11, 1'b1, 1'b1);
        conv_tick = 1'b1; step();
        expect_out("R9", 2'b10, 1'b0, 1'b0);
    endtask

    task automatic t_mode_change();
        conv_low = 1'b1;
        even_stb = 1'b1; step();              // armed in mode 10
        write_mode(2'b10);                    // same value: keep armed
        conv_tick = 1'b1; step();
        expect_out("R11", 2'b11, 1'b1, 1'b1);
        write_mode(2'b10);                    // same value in seed
        expect_out("R11", 2'b11, 1'b1, 1'b1);
        write_mode(2'b11);                    // change: back to idle
        expect_out("R11", 2'b10, 1'b0, 1'b0);
        conv_tick = 1'b1; step();
        expect_out("R11", 2'b10, 1'b0, 1'b0);
    endtask

    task automatic t_xy();
        write_mode(2'b00);
        conv_low = 1'b0; even_stb = 1'b1; odd_stb = 1'b0;
        expect_out("R10", 2'b00, 1'b1, 1'b0);
        even_stb = 1'b0; odd_stb = 1'b1;
        expect_out("R10", 2'b00, 1'b0, 1'b1);
        even_stb = 1'b1; step();
        conv_tick = 1'b1; step();
        odd_stb = 1'b0;
        expect_out("R10", 2'b00, 1'b0, 1'b0);
        write_mode(2'b01);
        odd_stb = 1'b1; conv_low = 1'b1;
        expect_out("R2", 2'b01, 1'b1, 1'b1);
        odd_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sampling();
        t_minmax();
        t_mode_change();
        t_xy();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule